// File: doc/BRIEF.md
# Synchronous Burst-Write Host Slave Port

This block is the write side of a clocked host port. A host processor drives a 32-bit data bus and a separate address bus, and it marks a transfer by pulling two active-low lines low: a chip select and a data strobe. When the direction line shows a write, the port waits a fixed number of cycles and then pulls its active-low ready output low. From then on it stores one word per clock into an internal synchronous memory, using the address that comes with each beat, so a burst can visit any addresses in any order. Two half-word enables choose which 16-bit halves of each word are written. The host ends the burst by pulling an active-low last-beat flag low during the final beat.

Each completed burst leaves one command in a small internal queue, holding the address of its final beat, for the engine behind the memory to take. When that queue is full, the active-low stop output falls and no new burst is started until the engine takes an entry. The engine side also has a registered read port into the memory.

The controller has four states. IDLE is the rest state. START (IDLE to WAIT) is taken when select and strobe are low, the direction line is low and the queue has room. SKIP (IDLE to DONE) is taken when select and strobe are low with the direction line high. EXPIRE (WAIT to DATA) is taken when the wait count has run out. LAST (DATA to DONE) is taken when a beat is captured with the last-beat flag low. ABORT (WAIT or DATA to IDLE) is taken when select or strobe rises before the last beat. RELEASE (DONE to IDLE) is taken when select and strobe are both high.

Top module: `hbw_slave`

## Requirements
- R1: After reset, ready and stop are high, the queue is empty (eng_valid low) and the controller is in IDLE.
- R2: When a write start is sampled at clock edge k, ready goes low after edge k+WAIT_CYC and not earlier. It therefore sits low for the whole cycle before the first capture edge.
- R3: On every edge where ready is low and select and strobe are both low, the word on wdata is written to the memory at the address on addr for that same beat. One word is captured per clock.
- R4: A beat captured with last_n low is the final one: ready is high from the next cycle, and no further word is captured until a new burst.
- R5: wen bit 0 enables bits 15:0 and wen bit 1 enables bits 31:16 of the stored word. A half whose enable is 0 keeps its old contents.
- R6: If select or strobe rises while in WAIT or DATA, the burst aborts: ready returns high, the current and later beats are not written, and no command is queued.
- R7: If the direction line rd_wr_n is high when select and strobe first go low, nothing is written, ready stays high and no command is queued.
- R8: After the final beat (or a skipped read), the controller stays in DONE with ready high until select and strobe are both high. A held select/strobe pair cannot start a second burst.
- R9: Each completed write burst pushes the address of its final beat into a queue of QDEPTH entries. eng_valid is high with eng_cmd showing the oldest entry, and eng_pop removes it, in first-in first-out order.
- R10: stop_n is low exactly while the queue holds QDEPTH entries. While it is low, a write start is held off: ready stays high and nothing is captured until an entry is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Chip select, active low |
| strb_n | input | 1 | Data strobe, active low |
| rd_wr_n | input | 1 | Direction, low for write, sampled at burst start |
| addr | input | ADDR_W | Word address of the current beat |
| wen | input | 2 | Half-word enables, bit 0 low half, bit 1 high half |
| last_n | input | 1 | Final-beat flag, active low |
| wdata | input | 2*LANE_W | Write data of the current beat |
| rdy_n | output | 1 | Ready, active low, one capture per clock while low |
| stop_n | output | 1 | Back-pressure, low while the command queue is full |
| eng_pop | input | 1 | Engine removes the oldest queued command |
| eng_valid | output | 1 | Command queue not empty |
| eng_cmd | output | ADDR_W | Final-beat address of the oldest completed burst |
| mem_raddr | input | ADDR_W | Engine read address into the memory |
| mem_rdata | output | 2*LANE_W | Memory word, one cycle after mem_raddr |

## Verification
The bench builds the block with WAIT_CYC of 2, QDEPTH of 2 and a 64-word memory. The two-cycle wait makes the exact cycle of the first ready fall measurable against the start edge. The two-entry queue fills after only two bursts, so the stop path, a start held off by it and the release after one pop are all covered in a short run. The small address space lets a bench-side model memory follow every half-word write and abort and compare every word read back.

// File: rtl/hbw_pkg.sv
package hbw_pkg;

    // Controller states of the burst-write port
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DATA = 2'd2,
        ST_DONE = 2'd3
    } hbw_state_e;

    // Number of 16-bit lanes in one bus word
    localparam int unsigned HBW_LANES = 2;

endpackage

// File: rtl/hbw_ctrl.sv
module hbw_ctrl
    import hbw_pkg::*;
#(
    parameter int unsigned WAIT_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_n,
    input  logic       strb_n,
    input  logic       rd_wr_n,
    input  logic       last_n,
    input  logic       q_full,
    output logic       rdy_n,
    output logic       cap,
    output logic       fin,
    output hbw_state_e state_o
);

    localparam int unsigned CNT_W = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYC - 1);

    hbw_state_e       state_q, state_d;
    logic [CNT_W-1:0] wcnt_q;
    logic             active;

    assign active = !sel_n && !strb_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Wait counter: runs only while in WAIT
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt_q <= '0;
        end else if (state_q == ST_WAIT && active) begin
            wcnt_q <= wcnt_q + 1'b1;
        end else begin
            wcnt_q <= '0;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (active) begin
                    if (rd_wr_n) begin
                        state_d = ST_DONE;          // SKIP
                    end else if (!q_full) begin
                        state_d = ST_WAIT;          // START
                    end
                end
            end
            ST_WAIT: begin
                if (!active) begin
                    state_d = ST_IDLE;              // ABORT
                end else if (wcnt_q == CNT_LAST) begin
                    state_d = ST_DATA;              // EXPIRE
                end
            end
            ST_DATA: begin
                if (!active) begin
                    state_d = ST_IDLE;              // ABORT
                end else if (!last_n) begin
                    state_d = ST_DONE;              // LAST
                end
            end
            ST_DONE: begin
                if (sel_n && strb_n) begin
                    state_d = ST_IDLE;              // RELEASE
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        rdy_n   = 1'b1;
        cap     = 1'b0;
        fin     = 1'b0;
        state_o = state_q;
        unique case (state_q)
            ST_DATA: begin
                rdy_n = 1'b0;
                cap   = active;
                fin   = active && !last_n;
            end
            ST_IDLE, ST_WAIT, ST_DONE: begin
                rdy_n = 1'b1;
            end
            default: rdy_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/hbw_mem.sv
module hbw_mem #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANE_W = 16,
    parameter int unsigned LANES  = 2
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         waddr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    input  logic [LANES-1:0]          lane_en,
    input  logic [ADDR_W-1:0]         raddr,
    output logic [LANES*LANE_W-1:0]   rdata
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] arr [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (we && lane_en[g]) begin
                arr[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        always_ff @(posedge clk) begin
            rd_q <= arr[raddr];
        end

        assign rdata[g*LANE_W +: LANE_W] = rd_q;
    end

endmodule

// File: rtl/hbw_cmdq.sv
module hbw_cmdq #(
    parameter int unsigned W     = 6,
    parameter int unsigned DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         valid,
    output logic         full
);

    localparam int unsigned PTR_W = (DEPTH < 2) ? 1 : $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [W-1:0]     slots [DEPTH];
    logic [PTR_W-1:0] wp_q, rp_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign full    = (cnt_q == CNT_FULL);
    assign valid   = (cnt_q != '0);
    assign do_push = push && !full;
    assign do_pop  = pop && valid;
    assign dout    = slots[rp_q];

    always_ff @(posedge clk) begin
        if (do_push) begin
            slots[wp_q] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) begin
                wp_q <= (wp_q == PTR_TOP) ? '0 : wp_q + 1'b1;
            end
            if (do_pop) begin
                rp_q <= (rp_q == PTR_TOP) ? '0 : rp_q + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/hbw_slave.sv
module hbw_slave
    import hbw_pkg::*;
#(
    parameter int unsigned ADDR_W   = 6,
    parameter int unsigned LANE_W   = 16,
    parameter int unsigned WAIT_CYC = 2,
    parameter int unsigned QDEPTH   = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            sel_n,
    input  logic                            strb_n,
    input  logic                            rd_wr_n,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [1:0]                      wen,
    input  logic                            last_n,
    input  logic [HBW_LANES*LANE_W-1:0]     wdata,
    output logic                            rdy_n,
    output logic                            stop_n,
    input  logic                            eng_pop,
    output logic                            eng_valid,
    output logic [ADDR_W-1:0]               eng_cmd,
    input  logic [ADDR_W-1:0]               mem_raddr,
    output logic [HBW_LANES*LANE_W-1:0]     mem_rdata
);

    logic       cap_w;
    logic       fin_w;
    logic       q_full;
    hbw_state_e state_w;

    hbw_ctrl #(
        .WAIT_CYC (WAIT_CYC)
    ) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_n   (sel_n),
        .strb_n  (strb_n),
        .rd_wr_n (rd_wr_n),
        .last_n  (last_n),
        .q_full  (q_full),
        .rdy_n   (rdy_n),
        .cap     (cap_w),
        .fin     (fin_w),
        .state_o (state_w)
    );

    hbw_mem #(
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W),
        .LANES  (HBW_LANES)
    ) mem_i (
        .clk     (clk),
        .we      (cap_w),
        .waddr   (addr),
        .wdata   (wdata),
        .lane_en (wen),
        .raddr   (mem_raddr),
        .rdata   (mem_rdata)
    );

    hbw_cmdq #(
        .W     (ADDR_W),
        .DEPTH (QDEPTH)
    ) cmdq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fin_w),
        .din   (addr),
        .pop   (eng_pop),
        .dout  (eng_cmd),
        .valid (eng_valid),
        .full  (q_full)
    );

    assign stop_n = !q_full;

endmodule

// File: rtl/hbw_slave_chk.sv
module hbw_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic sel_n,
    input logic strb_n,
    input logic last_n,
    input logic rdy_n,
    input logic stop_n,
    input logic eng_pop,
    input logic wr_en
);

    // R3
    wr_only_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (!rdy_n && !sel_n && !strb_n));

    // R4
    last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_n && !sel_n && !strb_n && !last_n) |=> rdy_n);

    // R6
    abort_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_n && (sel_n || strb_n)) |=> rdy_n);

    // R2
    rdy_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_n) |-> $past(!sel_n && !strb_n));

    // R10
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_n && !eng_pop) |=> !stop_n);

    // R10
    stop_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_n && rdy_n) |=> rdy_n);

endmodule

bind hbw_slave hbw_slave_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_n   (sel_n),
    .strb_n  (strb_n),
    .last_n  (last_n),
    .rdy_n   (rdy_n),
    .stop_n  (stop_n),
    .eng_pop (eng_pop),
    .wr_en   (cap_w)
);

// File: tb/hbw_slave_tb_top.sv
module hbw_slave_tb_top;

    localparam int unsigned ADDR_W   = 6;
    localparam int unsigned WAIT_CYC = 2;
    localparam int unsigned QDEPTH   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sel_n = 1'b1, strb_n = 1'b1, rd_wr_n = 1'b0, last_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [1:0]        wen = 2'b11;
    logic [31:0]       wdata = '0;
    logic              rdy_n, stop_n, eng_valid;
    logic              eng_pop = 1'b0;
    logic [ADDR_W-1:0] eng_cmd;
    logic [ADDR_W-1:0] mem_raddr = '0;
    logic [31:0]       mem_rdata;

    int errors = 0;
    int checks = 0;
    bit done_flag = 0;

    logic [31:0]       model [64];
    logic [ADDR_W-1:0] ba [8];
    logic [31:0]       bd [8];
    logic [1:0]        bw [8];
    logic [ADDR_W-1:0] exp_q [$];

    always #5 clk = ~clk;

    hbw_slave #(
        .ADDR_W   (ADDR_W),
        .LANE_W   (16),
        .WAIT_CYC (WAIT_CYC),
        .QDEPTH   (QDEPTH)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n     (sel_n),
        .strb_n    (strb_n),
        .rd_wr_n   (rd_wr_n),
        .addr      (addr),
        .wen       (wen),
        .last_n    (last_n),
        .wdata     (wdata),
        .rdy_n     (rdy_n),
        .stop_n    (stop_n),
        .eng_pop   (eng_pop),
        .eng_valid (eng_valid),
        .eng_cmd   (eng_cmd),
        .mem_raddr (mem_raddr),
        .mem_rdata (mem_rdata)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic present(int i);
        addr   = ba[i];
        wdata  = bd[i];
        wen    = bw[i];
        last_n = 1'b1;
    endtask

    task automatic model_write(int i);
        if (bw[i][0]) model[ba[i]][15:0]  = bd[i][15:0];
        if (bw[i][1]) model[ba[i]][31:16] = bd[i][31:16];
    endtask

    // Driver: runs a write burst of n beats from the current negedge and
    // pushes the expected command into the scoreboard queue.
    task automatic do_burst(int n);
        int  i = 0;
        int  cyc = 0;
        bit  first = 1;
        logic r;
        sel_n = 1'b0; strb_n = 1'b0; rd_wr_n = 1'b0;
        present(0);
        last_n = (n == 1) ? 1'b0 : 1'b1;
        while (i < n && cyc < 200) begin
            r = rdy_n;
            @(negedge clk);
            cyc++;
            if (!r) begin
                if (first) begin
                    // R2: ready first seen low WAIT_CYC+1 cycles after start
                    check("R2 ready latency", cyc - 1, WAIT_CYC + 1);
                    first = 0;
                end
                model_write(i);
                i++;
                if (i < n) begin
                    present(i);
                    last_n = (i == n - 1) ? 1'b0 : 1'b1;
                end
            end
        end
        exp_q.push_back(ba[n-1]);
        check("R4 ready high after last", {31'd0, rdy_n}, 32'd1);
        // R8: held select/strobe keeps DONE, no new burst
        repeat (3) begin
            @(negedge clk);
            check("R8 held in DONE", {31'd0, rdy_n}, 32'd1);
        end
        sel_n = 1'b1; strb_n = 1'b1; last_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic readback(logic [ADDR_W-1:0] a, string req);
        mem_raddr = a;
        @(negedge clk);
        check(req, mem_rdata, model[a]);
    endtask

    task automatic pop_cmd();
        eng_pop = 1'b1;
        @(negedge clk);
        eng_pop = 1'b0;
    endtask

    // Monitor: compares each popped command with the scoreboard queue
    always @(posedge clk) begin
        if (rst_n && eng_pop) begin
            checks++;
            if (!eng_valid || exp_q.size() == 0) begin
                errors++;
                $display("FAIL R9: pop with valid %0d queue %0d expected both nonzero",
                         eng_valid, exp_q.size());
            end else begin
                logic [ADDR_W-1:0] e;
                e = exp_q.pop_front();
                if (eng_cmd !== e) begin
                    errors++;
                    $display("FAIL R9: command actual %h expected %h", eng_cmd, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 ready at reset", {31'd0, rdy_n}, 32'd1);
        check("R1 stop at reset", {31'd0, stop_n}, 32'd1);
        check("R1 queue empty at reset", {31'd0, eng_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", {31'd0, rdy_n}, 32'd1);

        // R3: random-address burst of four beats
        ba[0] = 6'd3;  bd[0] = 32'hA1B2_C3D4; bw[0] = 2'b11;
        ba[1] = 6'd17; bd[1] = 32'h1111_2222; bw[1] = 2'b11;
        ba[2] = 6'd40; bd[2] = 32'hDEAD_BEEF; bw[2] = 2'b11;
        ba[3] = 6'd9;  bd[3] = 32'h0BAD_F00D; bw[3] = 2'b11;
        do_burst(4);
        readback(6'd3,  "R3 beat 0");
        readback(6'd17, "R3 beat 1");
        readback(6'd40, "R3 beat 2");
        readback(6'd9,  "R3 beat 3");
        pop_cmd();

        // R4: single-beat burst with last flag on the first beat
        ba[0] = 6'd5; bd[0] = 32'h5555_AAAA; bw[0] = 2'b11;
        do_burst(1);
        readback(6'd5, "R4 single beat");
        pop_cmd();

        // R5: half-word enables
        ba[0] = 6'd3;  bd[0] = 32'hFFFF_0001; bw[0] = 2'b01;
        ba[1] = 6'd17; bd[1] = 32'h7777_EEEE; bw[1] = 2'b10;
        ba[2] = 6'd40; bd[2] = 32'h0000_0000; bw[2] = 2'b00;
        do_burst(3);
        readback(6'd3,  "R5 low half only");
        readback(6'd17, "R5 high half only");
        readback(6'd40, "R5 no half");
        pop_cmd();
        check("R9 queue drained", {31'd0, eng_valid}, 32'd0);

        // R7: read direction leaves memory untouched
        sel_n = 1'b0; strb_n = 1'b0; rd_wr_n = 1'b1;
        addr = 6'd3; wdata = 32'h9999_9999; wen = 2'b11; last_n = 1'b0;
        repeat (8) begin
            @(negedge clk);
            check("R7 ready stays high on read", {31'd0, rdy_n}, 32'd1);
        end
        sel_n = 1'b1; strb_n = 1'b1; rd_wr_n = 1'b0; last_n = 1'b1;
        @(negedge clk);
        readback(6'd3, "R7 memory unchanged");
        check("R7 no command queued", {31'd0, eng_valid}, 32'd0);

        // R6: abort in the middle of a burst
        ba[0] = 6'd21; bd[0] = 32'h2121_2121; bw[0] = 2'b11;
        do_burst(1);
        pop_cmd();
        ba[0] = 6'd20; bd[0] = 32'h2020_2020; bw[0] = 2'b11;
        ba[1] = 6'd21; bd[1] = 32'hBADB_ADBA; bw[1] = 2'b11;
        sel_n = 1'b0; strb_n = 1'b0; rd_wr_n = 1'b0;
        present(0);
        begin
            logic r;
            int guard = 0;
            r = 1'b1;
            while (r && guard < 50) begin
                r = rdy_n;
                @(negedge clk);
                guard++;
            end
        end
        model_write(0);
        present(1);
        strb_n = 1'b1;
        @(negedge clk);
        check("R6 ready high after abort", {31'd0, rdy_n}, 32'd1);
        sel_n = 1'b1;
        @(negedge clk);
        readback(6'd20, "R6 beat before abort written");
        readback(6'd21, "R6 beat after abort not written");
        check("R6 no command after abort", {31'd0, eng_valid}, 32'd0);

        // R10: fill the queue, then a start is held off
        ba[0] = 6'd30; bd[0] = 32'h3030_3030; bw[0] = 2'b11;
        do_burst(1);
        ba[0] = 6'd31; bd[0] = 32'h3131_3131; bw[0] = 2'b11;
        do_burst(1);
        check("R10 stop low when full", {31'd0, stop_n}, 32'd0);
        ba[0] = 6'd32; bd[0] = 32'h3232_3232; bw[0] = 2'b11;
        sel_n = 1'b0; strb_n = 1'b0; rd_wr_n = 1'b0;
        present(0);
        last_n = 1'b0;
        repeat (6) begin
            @(negedge clk);
            check("R10 ready held while stopped", {31'd0, rdy_n}, 32'd1);
        end
        readback(6'd32, "R10 nothing captured while stopped");
        pop_cmd();
        check("R10 stop high after pop", {31'd0, stop_n}, 32'd1);
        do_burst(1);
        readback(6'd32, "R10 burst proceeds after pop");
        check("R10 stop low when full again", {31'd0, stop_n}, 32'd0);
        pop_cmd();
        pop_cmd();
        check("R9 queue empty after pops", {31'd0, eng_valid}, 32'd0);
        check("R9 scoreboard drained", exp_q.size(), 32'd0);
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        for (int k = 0; k < 64; k++) model[k] = 32'hxxxx_xxxx;
        model[32] = 32'hxxxx_xxxx;
    end

endmodule